// File: doc/BRIEF.md
# Device Access Permission Checker

This block rules on whether a memory request issued by a device may proceed. Each request carries a source ID, a start address, a byte length and a read/write flag. The source ID selects a bitmap of memory domains. Every rule entry belongs to one domain, so only the entries of the domains in that bitmap take part in the decision. Each entry is a top-of-range region with read and write permissions. The response gives allow or deny, whether a rule entry decided the outcome, and that entry's index.

The leading entries, up to a count held in a run-time register, are priority entries, and the lowest-indexed one of them that touches the access decides. Entries past that count are searched for any one that fully covers the access and grants the permission. Entries and source maps carry lock bits, and a write to a locked item is dropped. While software signals that it is programming, the checker stops accepting requests. Each request is accepted through a valid/ready handshake and its result appears one cycle later.

When the design parameter for the number of sources is 1, the block ignores the request ID and writes to the source map. Every request and every map write then uses source 0.

Top module: `pmp_chk`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0. Every entry is off (`ent_tor`=0), so any request is denied with `rsp_hit`=0.
- R2: While `prog_active` is 1, `req_ready` is 0 and no request is accepted. A request held through that time is accepted in the first cycle after `prog_active` drops.
- R3: `rsp_valid` is 1 for exactly the cycle after a cycle in which `req_valid` and `req_ready` were both 1, and is 0 otherwise.
- R4: An entry takes part in a check only if bit `md` of the source map selected by `req_id` is 1. `md` is the domain index written with the entry.
- R5: An enabled entry i covers the byte addresses from the address of entry i-1, inclusive, up to its own address, exclusive. Entry 0 starts at address 0. An access spans `req_addr` through `req_addr+req_len`.
- R6: Entries with index below the priority count are priority entries. The lowest-indexed priority entry that overlaps the access sets `rsp_hit`=1 and `rsp_idx` to its index. It allows the access only if it covers the access fully and holds the permission (`ent_w` for writes, `ent_r` for reads).
- R7: A priority entry that only partly covers the access denies it, even if it holds the needed permission.
- R8: If no priority entry overlaps the access, the access is allowed when some non-priority entry fully covers it and holds the permission. `rsp_idx` is then the lowest such index and `rsp_hit`=1. Otherwise the access is denied with `rsp_hit`=0.
- R9: The priority count resets to parameter `PRIO_RST` and takes `prio_val` when `prio_we` is 1.
- R10: A write to an entry whose lock bit is set is ignored. The lock bit is cleared only by reset.
- R11: A write to a source map whose lock bit is set is ignored. The lock bit is cleared only by reset.
- R12: With `N_SRC`=1, `req_id` and `map_src` are ignored, and every request and map write uses source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_active | input | 1 | Software is programming; hold off checks |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | EIW | Entry being written |
| ent_addr | input | AW | Top (exclusive) address of the entry |
| ent_tor | input | 1 | 1 enables the entry as top-of-range, 0 turns it off |
| ent_r | input | 1 | Read permission |
| ent_w | input | 1 | Write permission |
| ent_md | input | MDW | Domain the entry belongs to |
| ent_lock | input | 1 | Lock the entry after this write |
| map_we | input | 1 | Source map write strobe |
| map_src | input | IDW | Source whose map is written |
| map_md | input | N_MD | Domain membership bitmap |
| map_lock | input | 1 | Lock the map after this write |
| prio_we | input | 1 | Priority count write strobe |
| prio_val | input | PW | New priority count |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_id | input | IDW | Source ID of the request |
| req_addr | input | AW | First byte address |
| req_len | input | LW | Byte count minus one |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_allow | output | 1 | Access allowed |
| rsp_hit | output | 1 | A rule entry decided the result |
| rsp_idx | output | EIW | Index of the deciding entry |

## Verification
The assertions check the handshake timing and the lock rules on every cycle. A response never appears without an accepted request, and never while programming is active. A locked entry's address and a locked map keep their values across write attempts, lock bits never clear, and an allow always carries a hit. The decision itself is shown only by the bench's scenarios. These cover top-of-range bases and bounds, domain filtering, first-match priority with partial cover, the run-time priority count, and source-enforcement mode on a second instance.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;
   typedef enum logic {
      ENT_OFF = 1'b0,
      ENT_TOR = 1'b1
   } ent_mode_e;

   typedef struct packed {
      ent_mode_e mode;
      logic      r;
      logic      w;
   } ent_cfg_t;
endpackage

// File: rtl/pmp_chk_entries.sv
module pmp_chk_entries
   import pmp_chk_pkg::*;
#(
   parameter int AW    = 32,
   parameter int N_ENT = 8,
   parameter int N_MD  = 4,
   localparam int EIW  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int MDW  = (N_MD > 1) ? $clog2(N_MD) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [EIW-1:0]  idx,
   input  logic [AW-1:0]   addr,
   input  ent_cfg_t        cfg,
   input  logic [MDW-1:0]  md,
   input  logic            lock,
   output logic [AW-1:0]   addr_q [N_ENT],
   output ent_cfg_t        cfg_q  [N_ENT],
   output logic [MDW-1:0]  md_q   [N_ENT],
   output logic [N_ENT-1:0] lk_q
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      logic hit_wr;
      assign hit_wr = we && (idx == EIW'(i)) && !lk_q[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[i] <= '0;
            cfg_q[i]  <= '{mode: ENT_OFF, r: 1'b0, w: 1'b0};
            md_q[i]   <= '0;
            lk_q[i]   <= 1'b0;
         end else if (hit_wr) begin
            addr_q[i] <= addr;
            cfg_q[i]  <= cfg;
            md_q[i]   <= md;
            lk_q[i]   <= lock;
         end
      end
   end
endmodule

// File: rtl/pmp_chk_srcmap.sv
module pmp_chk_srcmap #(
   parameter int N_SRC = 4,
   parameter int N_MD  = 4,
   localparam int IDW  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDW-1:0]   src,
   input  logic [N_MD-1:0]  bits,
   input  logic             lock,
   output logic [N_MD-1:0]  map_q [N_SRC],
   output logic [N_SRC-1:0] lk_q
);
   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic hit_wr;
      assign hit_wr = we && (src == IDW'(s)) && !lk_q[s];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map_q[s] <= '0;
            lk_q[s]  <= 1'b0;
         end else if (hit_wr) begin
            map_q[s] <= bits;
            lk_q[s]  <= lock;
         end
      end
   end
endmodule

// File: rtl/pmp_chk_match.sv
module pmp_chk_match
   import pmp_chk_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LW    = 8,
   parameter int N_ENT = 8,
   parameter int N_MD  = 4,
   localparam int EIW  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int MDW  = (N_MD > 1) ? $clog2(N_MD) : 1,
   localparam int PW   = $clog2(N_ENT + 1)
) (
   input  logic [AW-1:0]   addr_q [N_ENT],
   input  ent_cfg_t        cfg_q  [N_ENT],
   input  logic [MDW-1:0]  md_q   [N_ENT],
   input  logic [N_MD-1:0] md_bits,
   input  logic [PW-1:0]   prio_cnt,
   input  logic [AW-1:0]   req_addr,
   input  logic [LW-1:0]   req_len,
   input  logic            req_write,
   output logic            allow,
   output logic            hit,
   output logic [EIW-1:0]  idx
);
   logic [AW:0] a_lo, a_hi;
   logic [N_ENT-1:0] ov, full, perm;

   assign a_lo = {1'b0, req_addr};
   assign a_hi = a_lo + (AW+1)'(req_len);

   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      logic [AW:0] base, top;
      logic        elig;
      if (i == 0) begin : g_first
         assign base = '0;
      end else begin : g_rest
         assign base = {1'b0, addr_q[i-1]};
      end
      assign top  = {1'b0, addr_q[i]};
      assign elig = (cfg_q[i].mode == ENT_TOR) && (int'(md_q[i]) < N_MD)
                    && md_bits[md_q[i]] && (base < top);
      assign ov[i]   = elig && (a_lo < top) && (a_hi >= base);
      assign full[i] = elig && (a_lo >= base) && (a_hi < top);
      assign perm[i] = req_write ? cfg_q[i].w : cfg_q[i].r;
   end

   always_comb begin
      logic           p_found, p_ok, n_found;
      logic [EIW-1:0] p_idx, n_idx;
      p_found = 1'b0;
      p_ok    = 1'b0;
      p_idx   = '0;
      n_found = 1'b0;
      n_idx   = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (i < int'(prio_cnt)) begin
            if (!p_found && ov[i]) begin
               p_found = 1'b1;
               p_idx   = EIW'(i);
               p_ok    = full[i] && perm[i];
            end
         end else if (!n_found && full[i] && perm[i]) begin
            n_found = 1'b1;
            n_idx   = EIW'(i);
         end
      end
      if (p_found) begin
         allow = p_ok;
         hit   = 1'b1;
         idx   = p_idx;
      end else begin
         allow = n_found;
         hit   = n_found;
         idx   = n_idx;
      end
   end
endmodule

// File: rtl/pmp_chk.sv
module pmp_chk
   import pmp_chk_pkg::*;
#(
   parameter int AW       = 32,
   parameter int LW       = 8,
   parameter int N_MD     = 4,
   parameter int N_SRC    = 4,
   parameter int N_ENT    = 8,
   parameter int PRIO_RST = 2,
   localparam int EIW     = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int MDW     = (N_MD > 1) ? $clog2(N_MD) : 1,
   localparam int IDW     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int PW      = $clog2(N_ENT + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prog_active,
   input  logic            ent_we,
   input  logic [EIW-1:0]  ent_idx,
   input  logic [AW-1:0]   ent_addr,
   input  logic            ent_tor,
   input  logic            ent_r,
   input  logic            ent_w,
   input  logic [MDW-1:0]  ent_md,
   input  logic            ent_lock,
   input  logic            map_we,
   input  logic [IDW-1:0]  map_src,
   input  logic [N_MD-1:0] map_md,
   input  logic            map_lock,
   input  logic            prio_we,
   input  logic [PW-1:0]   prio_val,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [IDW-1:0]  req_id,
   input  logic [AW-1:0]   req_addr,
   input  logic [LW-1:0]   req_len,
   input  logic            req_write,
   output logic            rsp_valid,
   output logic            rsp_allow,
   output logic            rsp_hit,
   output logic [EIW-1:0]  rsp_idx
);
   if (N_MD < 1 || N_MD > 63) begin : g_bad_md
      $error("pmp_chk: N_MD must lie in 1..63");
   end
   if (N_SRC < 1 || N_ENT < 1) begin : g_bad_cnt
      $error("pmp_chk: N_SRC and N_ENT must be at least 1");
   end
   if (PRIO_RST < 0 || PRIO_RST > N_ENT) begin : g_bad_prio
      $error("pmp_chk: PRIO_RST must lie in 0..N_ENT");
   end
   if (LW < 1 || LW >= AW) begin : g_bad_lw
      $error("pmp_chk: LW must lie in 1..AW-1");
   end

   logic [AW-1:0]    ent_addr_w [N_ENT];
   ent_cfg_t         ent_cfg_w  [N_ENT];
   logic [MDW-1:0]   ent_md_w   [N_ENT];
   logic [N_ENT-1:0] ent_lk_w;
   logic [N_MD-1:0]  map_w      [N_SRC];
   logic [N_SRC-1:0] map_lk_w;
   logic [IDW-1:0]   src_wr, src_rd;
   logic [PW-1:0]    prio_q;
   logic             m_allow, m_hit;
   logic [EIW-1:0]   m_idx;
   logic             accept;

   // Source-enforcement mode: a single source, ID forced to zero.
   if (N_SRC == 1) begin : g_sem
      assign src_wr = '0;
      assign src_rd = '0;
   end else begin : g_multi
      assign src_wr = map_src;
      assign src_rd = req_id;
   end

   pmp_chk_entries #(.AW(AW), .N_ENT(N_ENT), .N_MD(N_MD)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ent_we),
      .idx    (ent_idx),
      .addr   (ent_addr),
      .cfg    ('{mode: ent_mode_e'(ent_tor), r: ent_r, w: ent_w}),
      .md     (ent_md),
      .lock   (ent_lock),
      .addr_q (ent_addr_w),
      .cfg_q  (ent_cfg_w),
      .md_q   (ent_md_w),
      .lk_q   (ent_lk_w)
   );

   pmp_chk_srcmap #(.N_SRC(N_SRC), .N_MD(N_MD)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (map_we),
      .src   (src_wr),
      .bits  (map_md),
      .lock  (map_lock),
      .map_q (map_w),
      .lk_q  (map_lk_w)
   );

   pmp_chk_match #(.AW(AW), .LW(LW), .N_ENT(N_ENT), .N_MD(N_MD)) u_match (
      .addr_q    (ent_addr_w),
      .cfg_q     (ent_cfg_w),
      .md_q      (ent_md_w),
      .md_bits   ((int'(src_rd) < N_SRC) ? map_w[src_rd] : '0),
      .prio_cnt  (prio_q),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .req_write (req_write),
      .allow     (m_allow),
      .hit       (m_hit),
      .idx       (m_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prio_q <= PW'(PRIO_RST);
      else if (prio_we) prio_q <= prio_val;
   end

   assign req_ready = !prog_active;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_allow <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_idx   <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_allow <= m_allow;
            rsp_hit   <= m_hit;
            rsp_idx   <= m_idx;
         end
      end
   end
endmodule

// File: rtl/pmp_chk_sva.sv
module pmp_chk_sva #(
   parameter int AW    = 32,
   parameter int N_MD  = 4,
   parameter int N_SRC = 4,
   parameter int N_ENT = 8,
   localparam int EIW  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
   localparam int IDW  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             prog_active,
   input logic             req_valid,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_allow,
   input logic             rsp_hit,
   input logic             ent_we,
   input logic [EIW-1:0]   ent_idx,
   input logic             map_we,
   input logic [IDW-1:0]   src_wr,
   input logic [AW-1:0]    ent_addr_w [N_ENT],
   input logic [N_ENT-1:0] ent_lk_w,
   input logic [N_MD-1:0]  map_w [N_SRC],
   input logic [N_SRC-1:0] map_lk_w
);
   AST_STALL_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      prog_active |=> !rsp_valid); // R2

   AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid); // R3

   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> !rsp_valid); // R3

   AST_ALLOW_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_allow) |-> rsp_hit); // R8

   AST_ENT_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_we && (int'(ent_idx) < N_ENT) && ent_lk_w[ent_idx])
      |=> ent_addr_w[$past(ent_idx)] == $past(ent_addr_w[ent_idx])); // R10

   AST_ENT_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      |ent_lk_w |=> (($past(ent_lk_w) & ~ent_lk_w) == '0)); // R10

   AST_MAP_LOCK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (map_we && (int'(src_wr) < N_SRC) && map_lk_w[src_wr])
      |=> map_w[$past(src_wr)] == $past(map_w[src_wr])); // R11

   AST_MAP_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      |map_lk_w |=> (($past(map_lk_w) & ~map_lk_w) == '0)); // R11
endmodule

bind pmp_chk pmp_chk_sva #(.AW(AW), .N_MD(N_MD), .N_SRC(N_SRC), .N_ENT(N_ENT)) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .prog_active (prog_active),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_valid   (rsp_valid),
   .rsp_allow   (rsp_allow),
   .rsp_hit     (rsp_hit),
   .ent_we      (ent_we),
   .ent_idx     (ent_idx),
   .map_we      (map_we),
   .src_wr      (src_wr),
   .ent_addr_w  (ent_addr_w),
   .ent_lk_w    (ent_lk_w),
   .map_w       (map_w),
   .map_lk_w    (map_lk_w)
);

// File: tb/sim_pmp_chk.sv
`timescale 1ns/1ps
module sim_pmp_chk;
   localparam int AW = 32, LW = 8, N_MD = 4, N_SRC = 4, N_ENT = 8, PRIO_RST = 2;
   localparam int EIW = 3, MDW = 2, IDW = 2, PW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic prog_active = 1'b0;
   logic ent_we = 1'b0, ent_tor = 1'b0, ent_r = 1'b0, ent_w = 1'b0, ent_lock = 1'b0;
   logic [EIW-1:0] ent_idx = '0;
   logic [AW-1:0]  ent_addr = '0;
   logic [MDW-1:0] ent_md = '0;
   logic map_we = 1'b0, map_lock = 1'b0;
   logic [IDW-1:0]  map_src = '0;
   logic [N_MD-1:0] map_md = '0;
   logic prio_we = 1'b0;
   logic [PW-1:0] prio_val = '0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [IDW-1:0] req_id = '0;
   logic [AW-1:0]  req_addr = '0;
   logic [LW-1:0]  req_len = '0;
   logic req_ready, rsp_valid, rsp_allow, rsp_hit;
   logic [EIW-1:0] rsp_idx;
   logic s_ready, s_valid, s_allow, s_hit;
   logic [EIW-1:0] s_idx;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   pmp_chk #(.AW(AW), .LW(LW), .N_MD(N_MD), .N_SRC(N_SRC), .N_ENT(N_ENT),
             .PRIO_RST(PRIO_RST)) u0 (
      .clk(clk), .rst_n(rst_n), .prog_active(prog_active),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_addr(ent_addr), .ent_tor(ent_tor),
      .ent_r(ent_r), .ent_w(ent_w), .ent_md(ent_md), .ent_lock(ent_lock),
      .map_we(map_we), .map_src(map_src), .map_md(map_md), .map_lock(map_lock),
      .prio_we(prio_we), .prio_val(prio_val),
      .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
      .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
   );

   // Single-source instance for source-enforcement mode.
   pmp_chk #(.AW(AW), .LW(LW), .N_MD(N_MD), .N_SRC(1), .N_ENT(N_ENT),
             .PRIO_RST(PRIO_RST)) u1 (
      .clk(clk), .rst_n(rst_n), .prog_active(prog_active),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_addr(ent_addr), .ent_tor(ent_tor),
      .ent_r(ent_r), .ent_w(ent_w), .ent_md(ent_md), .ent_lock(ent_lock),
      .map_we(map_we), .map_src(map_src[0:0]), .map_md(map_md), .map_lock(map_lock),
      .prio_we(prio_we), .prio_val(prio_val),
      .req_valid(req_valid), .req_ready(s_ready), .req_id(req_id[0:0]),
      .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
      .rsp_valid(s_valid), .rsp_allow(s_allow), .rsp_hit(s_hit), .rsp_idx(s_idx)
   );

   task automatic chk(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_ent(int idx, logic [AW-1:0] a, bit r, bit w, int md, bit lk);
      @(negedge clk);
      ent_we = 1'b1; ent_idx = EIW'(idx); ent_addr = a; ent_tor = 1'b1;
      ent_r = r; ent_w = w; ent_md = MDW'(md); ent_lock = lk;
      @(negedge clk);
      ent_we = 1'b0;
   endtask

   task automatic wr_map(int src, logic [N_MD-1:0] bits, bit lk);
      @(negedge clk);
      map_we = 1'b1; map_src = IDW'(src); map_md = bits; map_lock = lk;
      @(negedge clk);
      map_we = 1'b0;
   endtask

   task automatic wr_prio(int v);
      @(negedge clk);
      prio_we = 1'b1; prio_val = PW'(v);
      @(negedge clk);
      prio_we = 1'b0;
   endtask

   task automatic req(string tag, int id, logic [AW-1:0] a, int len, bit wr,
                      bit e_allow, bit e_hit, int e_idx);
      @(negedge clk);
      req_valid = 1'b1; req_id = IDW'(id); req_addr = a;
      req_len = LW'(len); req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, "rsp_valid", int'(rsp_valid), 1);
      chk(tag, "rsp_allow", int'(rsp_allow), int'(e_allow));
      chk(tag, "rsp_hit", int'(rsp_hit), int'(e_hit));
      if (e_hit) chk(tag, "rsp_idx", int'(rsp_idx), e_idx);
      @(negedge clk);
      chk(tag, "rsp_valid drop", int'(rsp_valid), 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "req_ready", int'(req_ready), 1);
      chk("R1", "rsp_valid", int'(rsp_valid), 0);
      req("R1", 0, 32'h40, 0, 1'b0, 1'b0, 1'b0, 0);
   endtask

   task automatic t_tor();
      do_reset();
      wr_prio(0);
      wr_ent(0, 32'h100, 1, 0, 0, 0);
      wr_ent(1, 32'h200, 1, 1, 1, 0);
      wr_map(1, 4'b0011, 0);
      wr_map(2, 4'b0001, 0);
      req("R5 base0", 1, 32'h80, 3, 1'b0, 1'b1, 1'b1, 0);
      req("R8 noperm", 1, 32'h80, 3, 1'b1, 1'b0, 1'b0, 0);
      req("R5 mid", 1, 32'h180, 3, 1'b1, 1'b1, 1'b1, 1);
      req("R5 lastbyte", 1, 32'h1FC, 3, 1'b1, 1'b1, 1'b1, 1);
      req("R5 top excl", 1, 32'h1FD, 3, 1'b1, 1'b0, 1'b0, 0);
      req("R5 base incl", 1, 32'h100, 0, 1'b0, 1'b1, 1'b1, 1);
      req("R4 unmapped", 2, 32'h180, 0, 1'b1, 1'b0, 1'b0, 0);
      req("R4 mapped", 2, 32'h10, 0, 1'b0, 1'b1, 1'b1, 0);
   endtask

   task automatic t_prio();
      do_reset();
      wr_ent(0, 32'h100, 0, 0, 0, 0);
      wr_ent(1, 32'h300, 1, 1, 0, 0);
      wr_ent(2, 32'h400, 1, 1, 0, 0);
      wr_map(0, 4'b0001, 0);
      req("R6 prio deny", 0, 32'h80, 0, 1'b0, 1'b0, 1'b1, 0);
      req("R6 prio allow", 0, 32'h200, 7, 1'b1, 1'b1, 1'b1, 1);
      req("R7 partial noperm", 0, 32'hF0, 8'h1F, 1'b0, 1'b0, 1'b1, 0);
      req("R7 partial perm", 0, 32'h2F0, 8'h1F, 1'b0, 1'b0, 1'b1, 1);
      req("R8 nonprio", 0, 32'h350, 0, 1'b0, 1'b1, 1'b1, 2);
      wr_prio(0);
      req("R9 count0 span", 0, 32'hF0, 8'h1F, 1'b0, 1'b0, 1'b0, 0);
      req("R9 count0 inside", 0, 32'h200, 0, 1'b0, 1'b1, 1'b1, 1);
   endtask

   task automatic t_stall();
      do_reset();
      wr_ent(0, 32'h100, 1, 1, 0, 0);
      wr_map(0, 4'b0001, 0);
      @(negedge clk);
      prog_active = 1'b1;
      req_valid = 1'b1; req_id = '0; req_addr = 32'h20; req_len = '0; req_write = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R2", "req_ready", int'(req_ready), 0);
         chk("R2", "rsp_valid", int'(rsp_valid), 0);
      end
      prog_active = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", "rsp_valid after", int'(rsp_valid), 1);
      chk("R3", "rsp_allow", int'(rsp_allow), 1);
      @(negedge clk);
      chk("R3", "single pulse", int'(rsp_valid), 0);
   endtask

   task automatic t_lock();
      do_reset();
      wr_ent(0, 32'h100, 1, 0, 0, 1);
      wr_ent(0, 32'h1000, 1, 1, 0, 0);
      wr_map(0, 4'b0001, 1);
      wr_map(0, 4'b0000, 0);
      req("R10 perm kept", 0, 32'h80, 0, 1'b1, 1'b0, 1'b1, 0);
      req("R10 addr kept", 0, 32'h800, 0, 1'b0, 1'b0, 1'b0, 0);
      req("R11 map kept", 0, 32'h80, 0, 1'b0, 1'b1, 1'b1, 0);
   endtask

   task automatic t_sem();
      do_reset();
      wr_ent(0, 32'h100, 1, 0, 0, 0);
      wr_map(3, 4'b0000, 0);
      wr_map(0, 4'b0001, 0);
      @(negedge clk);
      req_valid = 1'b1; req_id = 2'd3; req_addr = 32'h10; req_len = '0; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12", "multi allow", int'(rsp_allow), 0);
      chk("R12", "single valid", int'(s_valid), 1);
      chk("R12", "single allow", int'(s_allow), 1);
      chk("R12", "single idx", int'(s_idx), 0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      t_reset();
      t_tor();
      t_prio();
      t_stall();
      t_lock();
      t_sem();
      finish_run();
   end
endmodule